// File: doc/BRIEF.md
# Sequential Search Classifier Controller

This controller decides which of ten classes an input belongs to. It has one shared compute unit, and at any moment that unit holds exactly one single-class detector configuration. The controller loads the configurations one after another, starting at page 0 and counting up. After each load it waits for the unit to return a score. That score comes back over a valid/ready handshake.

The controller has two search modes, and the mode is latched when a search starts. In the exhaustive mode every page is applied and every score is written to a small buffer. Only after the tenth score has been stored does a scan of the buffer choose the largest score. In the early-exit mode the controller compares each score with a programmable threshold as it arrives. It stops at the first score that is strictly above that threshold.

A finished search produces a one-cycle done pulse, the winning class, a no-match flag and the number of reconfigurations the decision cost. These outputs stay valid until the next search starts.

Top module: `seqclass_ctrl`

## Requirements
- R1: After reset, and whenever reset is asserted, `done_o`, `nomatch_o`, `cfg_req_o` and `score_ready_o` are 0, and `class_o` and `reconf_cnt_o` are 0.
- R2: Configuration pages are requested in ascending order from 0. Each request is a one-cycle `cfg_req_o` pulse with the page index on `cfg_page_o`. No new request is made until the score for the current page has been accepted. The number of requests equals the final `reconf_cnt_o`.
- R3: A score is taken only in a cycle where `score_valid_i` and `score_ready_o` are both 1. A score that is held back for any number of cycles leaves the search stalled on the same page.
- R4: When `mode_i`=1 at start (exhaustive), all 10 pages are applied before any decision. `class_o` is the index of the largest unsigned 16-bit score, and `reconf_cnt_o` is 10.
- R5: In exhaustive mode, when several pages share the largest score, the lowest of those indices wins.
- R6: When `mode_i`=0 at start (early exit), the search ends at the first page whose score is strictly greater than the threshold. `class_o` is that page and `reconf_cnt_o` is that page + 1.
- R7: In early-exit mode, if no score exceeds the threshold after page 9, `nomatch_o`=1 together with `done_o`, `class_o`=0 and `reconf_cnt_o`=10.
- R8: The 16-bit threshold is written when `thresh_wr_i`=1 and is kept across any number of searches until it is written again.
- R9: `start_i` and `mode_i` are ignored while a search is running. The running search finishes with its original mode and count.
- R10: `done_o` is high for exactly one cycle per search. `class_o`, `nomatch_o` and `reconf_cnt_o` hold their values after done until the next accepted start.
- R11: A score equal to the threshold does not end an early-exit search.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a search (sampled when idle) |
| mode_i | input | 1 | 1 = exhaustive argmax, 0 = early exit on threshold |
| thresh_wr_i | input | 1 | Load `thresh_i` into the threshold register |
| thresh_i | input | 16 | Threshold value |
| cfg_req_o | output | 1 | One-cycle request to load page `cfg_page_o` |
| cfg_page_o | output | 4 | Index of the page to load / currently active |
| score_valid_i | input | 1 | Score from the compute unit is valid |
| score_i | input | 16 | Unsigned detector score |
| score_ready_o | output | 1 | Controller can accept a score |
| class_o | output | 4 | Winning class |
| done_o | output | 1 | One-cycle pulse when a decision is ready |
| nomatch_o | output | 1 | Early-exit search found no score above threshold |
| reconf_cnt_o | output | 4 | Reconfigurations used by the current or last search |

## Verification
A wrong page counter shows up at once on `cfg_page_o` in the next request. A broken handshake shows as a mismatch between the number of requests and the scores the model has delivered, which becomes visible no later than the done pulse. Buffer or scan faults cannot be seen until the done pulse of an exhaustive search. They then show as a wrong `class_o`, and the vector table places winners at the first, a middle and the last index, with a tie, so that such faults are caught. A wrong threshold comparison appears as a wrong class or count at done: one vector has a score exactly at the threshold and one has a threshold of zero.

// File: rtl/seqclass_pkg.sv
package seqclass_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_REQ,
    ST_WAIT,
    ST_SCAN
  } seq_state_t;
endpackage

// File: rtl/seqclass_score_buf.sv
module seqclass_score_buf #(
  parameter int DEPTH   = 10,
  parameter int SCORE_W = 16
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       we_i,
  input  logic [$clog2(DEPTH)-1:0]   waddr_i,
  input  logic [SCORE_W-1:0]         wdata_i,
  input  logic [$clog2(DEPTH)-1:0]   raddr_i,
  output logic [SCORE_W-1:0]         rdata_o
);
  localparam int AW = $clog2(DEPTH);
  localparam logic [AW-1:0] TOP = AW'(DEPTH - 1);

  logic [SCORE_W-1:0] mem [DEPTH];

  // Plain synchronous write and registered read, so block RAM can be inferred.
  always_ff @(posedge clk) begin
    if (we_i) mem[waddr_i] <= wdata_i;
    rdata_o <= mem[raddr_i];
  end

  // R4
  buf_waddr_range_chk: assert property (@(posedge clk) disable iff (rst)
    we_i |-> waddr_i <= TOP);
endmodule

// File: rtl/seqclass_argmax.sv
module seqclass_argmax #(
  parameter int N_CLASS = 10,
  parameter int SCORE_W = 16
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         go_i,
  output logic [$clog2(N_CLASS)-1:0]   rd_addr_o,
  input  logic [SCORE_W-1:0]           rd_data_i,
  output logic                         fin_o,
  output logic [$clog2(N_CLASS)-1:0]   best_idx_o
);
  localparam int IW = $clog2(N_CLASS);
  localparam logic [IW-1:0] LAST = IW'(N_CLASS - 1);

  logic               act_q, cv_q, fin_q;
  logic [IW-1:0]      iss_q, cidx_q, best_i_q;
  logic [SCORE_W-1:0] best_s_q;

  assign rd_addr_o  = iss_q;
  assign fin_o      = fin_q;
  assign best_idx_o = best_i_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q    <= 1'b0;
      cv_q     <= 1'b0;
      fin_q    <= 1'b0;
      iss_q    <= '0;
      cidx_q   <= '0;
      best_i_q <= '0;
      best_s_q <= '0;
    end else begin
      fin_q  <= 1'b0;
      cv_q   <= act_q;
      cidx_q <= iss_q;
      if (go_i) begin
        act_q <= 1'b1;
        iss_q <= '0;
      end else if (act_q) begin
        if (iss_q == LAST) act_q <= 1'b0;
        else               iss_q <= iss_q + 1'b1;
      end
      if (cv_q) begin
        // Strict greater-than keeps the earlier index on a tie.
        if (cidx_q == '0 || rd_data_i > best_s_q) begin
          best_s_q <= rd_data_i;
          best_i_q <= cidx_q;
        end
        if (cidx_q == LAST) fin_q <= 1'b1;
      end
    end
  end

  // R5
  best_idx_range_chk: assert property (@(posedge clk) disable iff (rst)
    fin_o |-> best_idx_o <= LAST);

  // R4
  scan_step_chk: assert property (@(posedge clk) disable iff (rst)
    (cv_q && cidx_q != '0) |-> cidx_q == $past(cidx_q) + IW'(1));
endmodule

// File: rtl/seqclass_ctrl.sv
module seqclass_ctrl #(
  parameter int N_CLASS = 10,
  parameter int SCORE_W = 16
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic                               start_i,
  input  logic                               mode_i,
  input  logic                               thresh_wr_i,
  input  logic [SCORE_W-1:0]                 thresh_i,
  output logic                               cfg_req_o,
  output logic [$clog2(N_CLASS)-1:0]         cfg_page_o,
  input  logic                               score_valid_i,
  input  logic [SCORE_W-1:0]                 score_i,
  output logic                               score_ready_o,
  output logic [$clog2(N_CLASS)-1:0]         class_o,
  output logic                               done_o,
  output logic                               nomatch_o,
  output logic [$clog2(N_CLASS+1)-1:0]       reconf_cnt_o
);
  import seqclass_pkg::*;

  localparam int IW = $clog2(N_CLASS);
  localparam int CW = $clog2(N_CLASS + 1);
  localparam logic [IW-1:0] LAST = IW'(N_CLASS - 1);
  localparam logic [CW-1:0] FULL = CW'(N_CLASS);

  seq_state_t         state_q;
  logic               mode_q, done_q, nomatch_q;
  logic [IW-1:0]      page_q, class_q;
  logic [CW-1:0]      cnt_q;
  logic [SCORE_W-1:0] thresh_q;

  logic               take;
  logic               buf_we, scan_go, scan_fin;
  logic [IW-1:0]      rd_addr, best_idx;
  logic [SCORE_W-1:0] rd_data;

  assign take    = (state_q == ST_WAIT) && score_valid_i;
  assign buf_we  = take && mode_q;
  assign scan_go = buf_we && (page_q == LAST);

  seqclass_score_buf #(.DEPTH(N_CLASS), .SCORE_W(SCORE_W)) u_buf (
    .clk     (clk),
    .rst     (rst),
    .we_i    (buf_we),
    .waddr_i (page_q),
    .wdata_i (score_i),
    .raddr_i (rd_addr),
    .rdata_o (rd_data)
  );

  seqclass_argmax #(.N_CLASS(N_CLASS), .SCORE_W(SCORE_W)) u_scan (
    .clk        (clk),
    .rst        (rst),
    .go_i       (scan_go),
    .rd_addr_o  (rd_addr),
    .rd_data_i  (rd_data),
    .fin_o      (scan_fin),
    .best_idx_o (best_idx)
  );

  always_ff @(posedge clk) begin
    if (rst) thresh_q <= '0;
    else if (thresh_wr_i) thresh_q <= thresh_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      mode_q    <= 1'b0;
      done_q    <= 1'b0;
      nomatch_q <= 1'b0;
      page_q    <= '0;
      class_q   <= '0;
      cnt_q     <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          mode_q    <= mode_i;
          page_q    <= '0;
          cnt_q     <= '0;
          class_q   <= '0;
          nomatch_q <= 1'b0;
          state_q   <= ST_REQ;
        end
        ST_REQ: begin
          cnt_q   <= cnt_q + 1'b1;
          state_q <= ST_WAIT;
        end
        ST_WAIT: if (take) begin
          if (mode_q) begin
            if (page_q == LAST) state_q <= ST_SCAN;
            else begin
              page_q  <= page_q + 1'b1;
              state_q <= ST_REQ;
            end
          end else if (score_i > thresh_q) begin
            class_q <= page_q;
            done_q  <= 1'b1;
            state_q <= ST_IDLE;
          end else if (page_q == LAST) begin
            nomatch_q <= 1'b1;
            done_q    <= 1'b1;
            state_q   <= ST_IDLE;
          end else begin
            page_q  <= page_q + 1'b1;
            state_q <= ST_REQ;
          end
        end
        ST_SCAN: if (scan_fin) begin
          class_q <= best_idx;
          done_q  <= 1'b1;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign cfg_req_o     = (state_q == ST_REQ);
  assign score_ready_o = (state_q == ST_WAIT);
  assign cfg_page_o    = page_q;
  assign class_o       = class_q;
  assign done_o        = done_q;
  assign nomatch_o     = nomatch_q;
  assign reconf_cnt_o  = cnt_q;

  // R10
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  // R2
  one_cfg_chk: assert property (@(posedge clk) disable iff (rst)
    cfg_req_o |=> !cfg_req_o && score_ready_o);

  // R4
  exh_count_chk: assert property (@(posedge clk) disable iff (rst)
    (done_o && mode_q) |-> reconf_cnt_o == FULL);

  // R6
  hit_count_chk: assert property (@(posedge clk) disable iff (rst)
    (done_o && !mode_q && !nomatch_o) |-> reconf_cnt_o == CW'(class_o) + CW'(1));

  // R7
  nomatch_class_chk: assert property (@(posedge clk) disable iff (rst)
    nomatch_o |-> (class_o == '0 && reconf_cnt_o == FULL && !mode_q));

  // R9
  busy_start_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q != ST_IDLE && start_i) |=> reconf_cnt_o >= $past(reconf_cnt_o));
endmodule

// File: tb/seqclass_ctrl_bench.sv
`timescale 1ns/1ps
module seqclass_ctrl_bench;
  localparam int NC = 10;

  typedef struct packed {
    logic               mode;
    logic [15:0]        thr;
    logic [NC-1:0][15:0] sc;
    logic [3:0]         cls;
    logic               nm;
    logic [3:0]         cnt;
  } vec_t;

  // Fields: mode, threshold, scores (index 9 first), class, nomatch, count.
  localparam vec_t VECS [7] = '{
    '{1'b1, 16'd0, '{16'd50,16'd0,16'd1,16'd100,16'd7,16'd2,16'd100,16'd3,16'd9,16'd5}, 4'd3, 1'b0, 4'd10},
    '{1'b1, 16'd0, '{default:16'd0}, 4'd0, 1'b0, 4'd10},
    '{1'b1, 16'd0, '{16'd65535,16'd9,16'd8,16'd7,16'd6,16'd5,16'd4,16'd3,16'd2,16'd1}, 4'd9, 1'b0, 4'd10},
    '{1'b0, 16'd100, '{16'd0,16'd0,16'd0,16'd0,16'd0,16'd0,16'd7,16'd101,16'd100,16'd10}, 4'd2, 1'b0, 4'd3},
    '{1'b0, 16'd100, '{16'd0,16'd0,16'd0,16'd0,16'd0,16'd0,16'd0,16'd0,16'd0,16'd200}, 4'd0, 1'b0, 4'd1},
    '{1'b0, 16'd1000, '{default:16'd1000}, 4'd0, 1'b1, 4'd10},
    '{1'b0, 16'd0, '{16'd1,16'd0,16'd0,16'd0,16'd0,16'd0,16'd0,16'd0,16'd0,16'd0}, 4'd9, 1'b0, 4'd10}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_i = 1'b0, mode_i = 1'b0, thresh_wr_i = 1'b0;
  logic [15:0] thresh_i = '0;
  logic        cfg_req_o, score_ready_o, done_o, nomatch_o;
  logic [3:0]  cfg_page_o, class_o, reconf_cnt_o;
  logic        score_valid_i = 1'b0;
  logic [15:0] score_i = '0;

  int n_chk = 0;
  int n_fail = 0;
  logic [15:0] cur_thr = '0;

  always #2 clk = ~clk;

  seqclass_ctrl u_seqclass_ctrl (
    .clk(clk), .rst(rst), .start_i(start_i), .mode_i(mode_i),
    .thresh_wr_i(thresh_wr_i), .thresh_i(thresh_i),
    .cfg_req_o(cfg_req_o), .cfg_page_o(cfg_page_o),
    .score_valid_i(score_valid_i), .score_i(score_i), .score_ready_o(score_ready_o),
    .class_o(class_o), .done_o(done_o), .nomatch_o(nomatch_o), .reconf_cnt_o(reconf_cnt_o)
  );

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  task automatic load_thresh(input logic [15:0] t);
    @(negedge clk);
    thresh_wr_i = 1'b1;
    thresh_i = t;
    @(negedge clk);
    thresh_wr_i = 1'b0;
    thresh_i = 16'hFFFF;
    cur_thr = t;
  endtask

  // Runs one search with a detector model; poke re-pulses start with the other mode mid-search.
  task automatic run_vec(input vec_t v, input string tag, input bit poke);
    int  exp_pg = 0, nreq = 0, nacc = 0, wait_n = 0;
    bit  pending = 0, rdy_seen = 0, got_done = 0;
    logic [3:0] pg = '0;
    @(negedge clk);
    mode_i  = v.mode;
    start_i = 1'b1;
    for (int cyc = 0; cyc < 2000; cyc++) begin
      @(negedge clk);
      start_i = 1'b0;
      if (score_valid_i && rdy_seen) begin
        score_valid_i = 1'b0;
        nacc++;
      end
      if (done_o) begin
        got_done = 1;
        break;
      end
      if (cfg_req_o) begin
        nreq++;
        check(cfg_page_o == 4'(exp_pg) && !pending && !score_valid_i, "R2", "page order", int'(cfg_page_o), exp_pg);
        pg = cfg_page_o;
        exp_pg++;
        pending = 1;
        wait_n = int'(pg) % 3;
        if (poke && pg == 4'd1) begin
          start_i = 1'b1;
          mode_i  = ~v.mode;
        end
      end else if (pending) begin
        if (wait_n == 0) begin
          score_valid_i = 1'b1;
          score_i = v.sc[pg];
          pending = 0;
        end else begin
          wait_n--;
        end
      end
      rdy_seen = score_ready_o;
    end
    check(got_done, "R10", "done seen", int'(got_done), 1);
    check(class_o == v.cls, tag, "class", int'(class_o), int'(v.cls));
    check(nomatch_o == v.nm, v.nm ? "R7" : tag, "nomatch", int'(nomatch_o), int'(v.nm));
    check(reconf_cnt_o == v.cnt, tag, "reconf count", int'(reconf_cnt_o), int'(v.cnt));
    check(nreq == int'(v.cnt), "R2", "requests issued", nreq, int'(v.cnt));
    check(nacc == int'(v.cnt), "R3", "scores accepted", nacc, int'(v.cnt));
    repeat (3) @(negedge clk);
    check(!done_o, "R10", "done is one cycle", int'(done_o), 0);
    check(class_o == v.cls && nomatch_o == v.nm && reconf_cnt_o == v.cnt, "R10", "held class",
          int'(class_o), int'(v.cls));
    mode_i = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL R10 watchdog expired: actual 0 expected 1");
    report();
  end

  initial begin
    string tags [7] = '{"R5", "R4", "R4", "R11", "R8", "R7", "R6"};
    repeat (3) @(negedge clk);
    // R1: reset state
    check(!done_o && !nomatch_o && !cfg_req_o && !score_ready_o, "R1", "reset flags", 0, 0);
    check(class_o == 0 && reconf_cnt_o == 0, "R1", "reset class/count", int'(class_o), 0);
    rst = 1'b0;

    for (int i = 0; i < 7; i++) begin
      if (!VECS[i].mode && VECS[i].thr != cur_thr) load_thresh(VECS[i].thr);
      run_vec(VECS[i], tags[i], 1'b0);
    end

    // R9: restart attempt with flipped mode during an early-exit search
    load_thresh(16'd100);
    run_vec(VECS[3], "R9", 1'b1);

    // R8: threshold kept across an exhaustive search
    run_vec(VECS[0], "R4", 1'b0);
    run_vec(VECS[4], "R8", 1'b0);

    // R3: a held-back score stalls on page 0
    @(negedge clk);
    mode_i = 1'b1;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    repeat (8) @(negedge clk);
    check(score_ready_o && !cfg_req_o && cfg_page_o == 0 && reconf_cnt_o == 1, "R3", "stalled page",
          int'(reconf_cnt_o), 1);

    // R1: reset during a search
    rst = 1'b1;
    @(negedge clk);
    check(!score_ready_o && !cfg_req_o && !done_o && reconf_cnt_o == 0 && class_o == 0, "R1",
          "mid-search reset", int'(reconf_cnt_o), 0);
    rst = 1'b0;
    report();
  end
endmodule